// File: doc/BRIEF.md
# Page-Descriptor DMA Write Engine

This block moves a stream of incoming link data into host memory with no processor involvement in the transfer. Software provides buffers by pushing page base addresses into a free-page queue. When data arrives, the engine takes the oldest free page and writes the data beats into consecutive locations of that page through a simple address/data/valid/ready memory-write port.

A page is closed when it has been filled or when a beat flagged as the end of an event is written. Whichever comes first closes it. On closing, the engine pushes a completion record into a ready queue: the page base, the number of bytes written, an end-of-event flag and an error flag. Software reads these records back.

Both queues report their occupancy. The engine applies back-pressure instead of dropping data:
- With no free page available, the input is held off.
- With the ready queue full, the page cannot be closed and the input stalls until software removes a record.

Top module: `pgdesc_dma`

## Requirements
- R1: While reset is held, and on the first cycle after it, both occupancy counts are zero and `in_ready`, `mem_valid` and `rdy_valid` are low.
- R2: Each `free_push` on a cycle where `free_count` is below the queue depth stores one page address and raises `free_count` by one. A push while the queue is full is discarded, and that address is never used.
- R3: While no free page is available, `in_ready` and `mem_valid` stay low even with `in_valid` high.
- R4: Pages are used in the order they were pushed. Beat k of a page (counting from 0) is written to page base + 8·k, and `in_data` appears unchanged on `mem_data`.
- R5: After PAGE_BYTES/8 beats the page is closed. Its record carries length PAGE_BYTES, and its end-of-event flag equals `in_last` of the final beat.
- R6: A beat with `in_last` high closes the page at once. The record carries length 8 × (beats in the page) and end-of-event flag 1, and the next beat starts a new page.
- R7: A record's error flag is the OR of `in_err` over all beats written into that page.
- R8: While the ready queue is full, a closed page waits. During that time `in_ready` stays low and no further free page is taken. Once software removes a record, operation resumes with nothing lost.
- R9: Records leave the ready queue in closing order, one per `rdy_pop` while `rdy_valid` is high. A pop of the empty queue changes nothing.
- R10: While `mem_valid` is high and `mem_ready` is low, `in_ready` is low and `mem_addr` holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| free_push | input | 1 | Software writes a free page address |
| free_addr | input | ADDR_W | Free page base address |
| free_count | output | clog2(FIFO_DEPTH+1) | Entries in the free queue |
| in_valid | input | 1 | Input data beat valid |
| in_data | input | DATA_W | Input data beat |
| in_last | input | 1 | Beat is the last of an event |
| in_err | input | 1 | Beat carries an error |
| in_ready | output | 1 | Beat accepted this cycle when high with `in_valid` |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_data | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the write |
| rdy_valid | output | 1 | Ready queue holds a record |
| rdy_addr | output | ADDR_W | Record page base |
| rdy_len | output | clog2(PAGE_BYTES)+1 | Record byte length |
| rdy_last | output | 1 | Record holds the end of an event |
| rdy_err | output | 1 | An error was seen in the page |
| rdy_pop | input | 1 | Software removes the head record |
| rdy_count | output | clog2(FIFO_DEPTH+1) | Entries in the ready queue |

## Verification
The bench uses 32-byte pages and four-entry queues.

It sweeps event lengths from one to nine beats. This covers single-beat events, events that end exactly on a page boundary and events that spill over one or two page boundaries, so early closing is told apart from closing on a full page. Error beats fall on a changing set of positions, which separates per-page error accumulation from per-event accumulation. The sweep runs with irregular memory stalls while software refills pages concurrently, so address holding and page ordering are tested under changing timing.

Separate patterns cover:
- input with no pages at all;
- a push to a full free queue;
- a pop of an empty ready queue;
- a ready queue left full long enough to block the engine.

// File: rtl/pgdma_pkg.sv
// Shared types for the page-descriptor DMA engine.
// Assumes nothing beyond standard SystemVerilog packages.
package pgdma_pkg;

    // Page writer states: waiting for a page, moving beats, reporting the page.
    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_XFER  = 2'd1,
        WS_CLOSE = 2'd2
    } wr_state_e;

endpackage

// File: rtl/desc_fifo.sv
// Synchronous first-in first-out queue with an occupancy count.
// Pushes while full and pops while empty are ignored.
// The head entry is shown without a read delay.
// Assumes DEPTH is a power of two, at least 2.
module desc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    // Pointer and count bookkeeping for accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Entry storage; written only on accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= din;
    end

endmodule

// File: rtl/page_writer.sv
// Moves input beats into the current page and reports the page when it is
// full or when an end-of-event beat was written.
// A page is taken only when a beat is waiting.
// Assumes page bases are aligned to PAGE_BYTES, and that PAGE_BYTES is a
// multiple of the beat size.
module page_writer
    import pgdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int PAGE_BYTES = 4096,
    localparam int LEN_W      = $clog2(PAGE_BYTES) + 1,
    localparam int BEAT_BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_avail,
    input  logic [ADDR_W-1:0] page_addr,
    output logic              page_take,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_err,
    output logic              in_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_ready,
    input  logic              desc_space,
    output logic              desc_push,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [LEN_W-1:0]  desc_len,
    output logic              desc_last,
    output logic              desc_err
);

    wr_state_e         state;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  offset;
    logic              err_acc;
    logic              last_q;
    logic              beat;
    logic              page_end;

    assign page_take = (state == WS_IDLE) && in_valid && page_avail;
    assign mem_valid = (state == WS_XFER) && in_valid;
    assign mem_addr  = base + ADDR_W'(offset);
    assign mem_data  = in_data;
    assign in_ready  = (state == WS_XFER) && mem_ready;
    assign beat      = mem_valid && mem_ready;
    assign page_end  = (offset + LEN_W'(BEAT_BYTES)) == LEN_W'(PAGE_BYTES);
    assign desc_push = (state == WS_CLOSE) && desc_space;
    assign desc_addr = base;
    assign desc_len  = offset;
    assign desc_last = last_q;
    assign desc_err  = err_acc;

    // Page state machine with byte offset and flag accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= WS_IDLE;
            base    <= '0;
            offset  <= '0;
            err_acc <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            unique case (state)
                WS_IDLE: begin
                    if (page_take) begin
                        base    <= page_addr;
                        offset  <= '0;
                        err_acc <= 1'b0;
                        last_q  <= 1'b0;
                        state   <= WS_XFER;
                    end
                end
                WS_XFER: begin
                    if (beat) begin
                        offset  <= offset + LEN_W'(BEAT_BYTES);
                        err_acc <= err_acc | in_err;
                        last_q  <= in_last;
                        if (in_last || page_end) state <= WS_CLOSE;
                    end
                end
                WS_CLOSE: begin
                    if (desc_space) state <= WS_IDLE;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgdesc_dma.sv
// Top level of the page-descriptor DMA engine.
// A free-page queue feeds the page writer, and the writer's completion
// records fill a ready queue that software drains.
// Assumes software pushes only PAGE_BYTES-aligned page bases.
module pgdesc_dma #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                free_push,
    input  logic [ADDR_W-1:0]                   free_addr,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]     free_count,
    input  logic                                in_valid,
    input  logic [DATA_W-1:0]                   in_data,
    input  logic                                in_last,
    input  logic                                in_err,
    output logic                                in_ready,
    output logic                                mem_valid,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic [DATA_W-1:0]                   mem_data,
    input  logic                                mem_ready,
    output logic                                rdy_valid,
    output logic [ADDR_W-1:0]                   rdy_addr,
    output logic [$clog2(PAGE_BYTES):0]         rdy_len,
    output logic                                rdy_last,
    output logic                                rdy_err,
    input  logic                                rdy_pop,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]     rdy_count
);

    localparam int LEN_W  = $clog2(PAGE_BYTES) + 1;
    localparam int DESC_W = ADDR_W + LEN_W + 2;

    logic [ADDR_W-1:0] page_addr;
    logic              free_full;
    logic              free_empty;
    logic              page_take;
    logic              desc_push;
    logic [ADDR_W-1:0] desc_addr;
    logic [LEN_W-1:0]  desc_len;
    logic              desc_last;
    logic              desc_err;
    logic              rdy_full;
    logic              rdy_empty;
    logic [DESC_W-1:0] desc_in;
    logic [DESC_W-1:0] desc_out;

    assign desc_in   = {desc_addr, desc_len, desc_last, desc_err};
    assign rdy_valid = !rdy_empty;
    assign {rdy_addr, rdy_len, rdy_last, rdy_err} = desc_out;

    // Queue of page bases supplied by software.
    desc_fifo #(.W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_free (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (free_push),
        .din   (free_addr),
        .pop   (page_take),
        .dout  (page_addr),
        .full  (free_full),
        .empty (free_empty),
        .count (free_count)
    );

    // Writes beats into the current page and closes it.
    page_writer #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_avail (!free_empty),
        .page_addr  (page_addr),
        .page_take  (page_take),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_err     (in_err),
        .in_ready   (in_ready),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_ready  (mem_ready),
        .desc_space (!rdy_full),
        .desc_push  (desc_push),
        .desc_addr  (desc_addr),
        .desc_len   (desc_len),
        .desc_last  (desc_last),
        .desc_err   (desc_err)
    );

    // Queue of completion records for software.
    desc_fifo #(.W(DESC_W), .DEPTH(FIFO_DEPTH)) u_ready (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (desc_push),
        .din   (desc_in),
        .pop   (rdy_pop),
        .dout  (desc_out),
        .full  (rdy_full),
        .empty (rdy_empty),
        .count (rdy_count)
    );

    // Unused in the default build, kept so the free-full state stays visible.
    logic unused_ok;
    assign unused_ok = free_full;

endmodule

// File: rtl/pgdesc_dma_chk.sv
// Temporal checks on the port behaviour of pgdesc_dma.
// The module is bound into every instance of the top.
module pgdesc_dma_chk #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5,
    parameter int LEN_W      = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  free_count,
    input logic [CNT_W-1:0]  rdy_count,
    input logic              rdy_valid,
    input logic              rdy_pop,
    input logic              rdy_last,
    input logic [LEN_W-1:0]  rdy_len,
    input logic              in_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (free_count == '0 && rdy_count == '0 && !in_ready && !mem_valid));

    a_r2_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= CNT_W'(FIFO_DEPTH));

    a_r4_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[2:0] == 3'd0));

    a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |-> (rdy_len != '0 && rdy_len <= LEN_W'(PAGE_BYTES)));

    a_r6_short_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_valid && !rdy_last) |-> (rdy_len == LEN_W'(PAGE_BYTES)));

    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_count == CNT_W'(FIFO_DEPTH) && !rdy_pop) |=> (rdy_count == CNT_W'(FIFO_DEPTH)));

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_pop) |=> (rdy_count >= $past(rdy_count)));

    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> $stable(mem_addr));

    a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |-> !in_ready);

endmodule

bind pgdesc_dma pgdesc_dma_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      ($clog2(FIFO_DEPTH + 1)),
    .LEN_W      ($clog2(PAGE_BYTES) + 1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .free_count (free_count),
    .rdy_count  (rdy_count),
    .rdy_valid  (rdy_valid),
    .rdy_pop    (rdy_pop),
    .rdy_last   (rdy_last),
    .rdy_len    (rdy_len),
    .in_ready   (in_ready),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr)
);

// File: tb/pgdesc_dma_test.sv
// Scoreboard bench: 32-byte pages (4 beats), 4-entry queues.
module pgdesc_dma_test;

    localparam int AW    = 32;
    localparam int DW    = 64;
    localparam int PB    = 32;
    localparam int DEPTH = 4;
    localparam int BPP   = PB / 8;
    localparam int LW    = $clog2(PB) + 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          free_push = 1'b0;
    logic [AW-1:0] free_addr = '0;
    logic [CW-1:0] free_count;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          in_err = 1'b0;
    logic          in_ready;
    logic          mem_valid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          mem_ready = 1'b1;
    logic          rdy_valid;
    logic [AW-1:0] rdy_addr;
    logic [LW-1:0] rdy_len;
    logic          rdy_last;
    logic          rdy_err;
    logic          rdy_pop = 1'b0;
    logic [CW-1:0] rdy_count;

    pgdesc_dma #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .free_push(free_push), .free_addr(free_addr),
        .free_count(free_count), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready), .rdy_valid(rdy_valid), .rdy_addr(rdy_addr),
        .rdy_len(rdy_len), .rdy_last(rdy_last), .rdy_err(rdy_err),
        .rdy_pop(rdy_pop), .rdy_count(rdy_count)
    );

    always #4 clk = ~clk;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    bit mr_en = 1'b0;

    // Expected stream, filled by plan_event.
    logic [DW-1:0] b_data [256];
    bit            b_last [256];
    bit            b_err  [256];
    int            b_chunk[256];
    int            b_pos  [256];
    int            c_len  [64];
    bit            c_last [64];
    bit            c_err  [64];
    logic [AW-1:0] page_list[64];
    int n_beats = 0, n_chunks = 0, n_pages = 0;
    int drv_ptr = 0, chk_wr = 0, chk_ch = 0;
    int cur_pos = 0;
    bit cur_err = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Append one event of len beats to the expected stream.
    task automatic plan_event(input int len);
        for (int i = 0; i < len; i++) begin
            b_data[n_beats]  = 64'hC0DE_0000_0000_0000 | 64'(n_beats);
            b_last[n_beats]  = (i == len - 1);
            b_err[n_beats]   = ((n_beats * 3) % 7 == 2);
            b_chunk[n_beats] = n_chunks;
            b_pos[n_beats]   = cur_pos;
            cur_err = cur_err | b_err[n_beats];
            if (i == len - 1 || cur_pos == BPP - 1) begin
                c_len[n_chunks]  = (cur_pos + 1) * 8;
                c_last[n_chunks] = (i == len - 1);
                c_err[n_chunks]  = cur_err;
                n_chunks++;
                cur_pos = 0;
                cur_err = 0;
            end else begin
                cur_pos++;
            end
            n_beats++;
        end
    endtask

    task automatic send_beats(input int n);
        @(posedge clk); #1;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = b_data[drv_ptr];
            in_last  = b_last[drv_ptr];
            in_err   = b_err[drv_ptr];
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk); #1;
            drv_ptr++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_err   = 1'b0;
    endtask

    task automatic feed_pages(input int n);
        for (int i = 0; i < n; i++) begin
            forever begin
                @(negedge clk);
                if (free_count < CW'(DEPTH)) break;
            end
            @(posedge clk); #1;
            free_push = 1'b1;
            free_addr = 32'h2000_0000 + 32'(n_pages) * 32'h100;
            page_list[n_pages] = free_addr;
            n_pages++;
            @(posedge clk); #1;
            free_push = 1'b0;
        end
    endtask

    task automatic read_desc(input int n);
        for (int i = 0; i < n; i++) begin
            forever begin
                @(negedge clk);
                if (rdy_valid) break;
            end
            chk(rdy_addr == page_list[chk_ch], "R4 record page", 64'(rdy_addr), 64'(page_list[chk_ch]));
            chk(int'(rdy_len) == c_len[chk_ch], "R5/R6 record length", 64'(rdy_len), 64'(c_len[chk_ch]));
            chk(rdy_last == c_last[chk_ch], "R6 end-of-event flag", 64'(rdy_last), 64'(c_last[chk_ch]));
            chk(rdy_err == c_err[chk_ch], "R7 error flag", 64'(rdy_err), 64'(c_err[chk_ch]));
            chk_ch++;
            @(posedge clk); #1;
            rdy_pop = 1'b1;
            @(posedge clk); #1;
            rdy_pop = 1'b0;
        end
    endtask

    // Irregular memory stalls when enabled.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        mem_ready = !mr_en || ((cyc % 5 != 3) && (cyc % 7 != 0));
    end

    // Write monitor: checks every accepted write and every stall cycle.
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (chk_wr >= n_beats) begin
                chk(1'b0, "R3 unexpected write", 64'(mem_addr), 64'd0);
            end else begin
                chk(mem_addr == page_list[b_chunk[chk_wr]] + 32'(b_pos[chk_wr] * 8),
                    "R4 write address", 64'(mem_addr),
                    64'(page_list[b_chunk[chk_wr]] + 32'(b_pos[chk_wr] * 8)));
                chk(mem_data == b_data[chk_wr], "R4 write data", mem_data, b_data[chk_wr]);
                chk_wr++;
            end
        end
        if (rst_n && mem_valid && !mem_ready)
            chk(!in_ready, "R10 no accept during stall", 64'(in_ready), 64'd0);
    end

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (60000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(free_count == 0, "R1 free count in reset", 64'(free_count), 0);
        chk(rdy_count == 0, "R1 ready count in reset", 64'(rdy_count), 0);
        chk(!in_ready, "R1 in_ready in reset", 64'(in_ready), 0);
        chk(!mem_valid, "R1 mem_valid in reset", 64'(mem_valid), 0);
        chk(!rdy_valid, "R1 rdy_valid in reset", 64'(rdy_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R3: data offered with no page.
        in_valid = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!in_ready, "R3 in_ready with no page", 64'(in_ready), 0);
            chk(!mem_valid, "R3 mem_valid with no page", 64'(mem_valid), 0);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;

        // R9: pop of an empty ready queue.
        rdy_pop = 1'b1;
        @(posedge clk); #1;
        rdy_pop = 1'b0;
        @(negedge clk);
        chk(rdy_count == 0, "R9 empty pop count", 64'(rdy_count), 0);
        chk(!rdy_valid, "R9 empty pop valid", 64'(rdy_valid), 0);

        // R2: fill the free queue, then overflow it.
        for (int i = 0; i < DEPTH; i++) begin
            feed_pages(1);
            @(negedge clk);
            chk(int'(free_count) == i + 1, "R2 free count step", 64'(free_count), 64'(i + 1));
        end
        @(posedge clk); #1;
        free_push = 1'b1;
        free_addr = 32'hDEAD_0000;
        @(posedge clk); #1;
        free_push = 1'b0;
        @(negedge clk);
        chk(int'(free_count) == DEPTH, "R2 push while full", 64'(free_count), 64'(DEPTH));

        // Sweep of event lengths 1..9 with stalls and concurrent refill.
        for (int len = 1; len <= 9; len++) plan_event(len);
        mr_en = 1'b1;
        fork
            send_beats(n_beats - drv_ptr);
            feed_pages(n_chunks - n_pages);
            read_desc(n_chunks - chk_ch);
        join
        mr_en = 1'b0;
        @(negedge clk);
        chk(chk_wr == n_beats, "R4 all beats written", 64'(chk_wr), 64'(n_beats));

        // R8: ready queue left full.
        for (int i = 0; i < 6; i++) plan_event(1);
        feed_pages(DEPTH);
        fork
            send_beats(5);
            feed_pages(2);
        join
        repeat (6) @(negedge clk);
        chk(int'(rdy_count) == DEPTH, "R8 ready queue full", 64'(rdy_count), 64'(DEPTH));
        chk(free_count == 1, "R8 no page taken while blocked", 64'(free_count), 1);
        fork
            send_beats(1);
            begin
                for (int i = 0; i < 5; i++) begin
                    @(negedge clk);
                    chk(!in_ready, "R8 input stalled", 64'(in_ready), 0);
                end
                read_desc(6);
            end
        join
        repeat (4) @(negedge clk);
        chk(free_count == 0, "R8 final free count", 64'(free_count), 0);
        chk(rdy_count == 0, "R9 final ready count", 64'(rdy_count), 0);
        chk(chk_wr == n_beats, "R4 final beat total", 64'(chk_wr), 64'(n_beats));
        finish_run();
    end

endmodule